// File: doc/BRIEF.md
# Streaming Vector Lane with Register File

This block is a small vector execution unit. It keeps a file of 32 vector registers, each made of 64 integer elements of 64 bits, and runs one of two add instructions at a time over a whole register. An instruction names a destination register and one or two sources. It adds the two sources element by element, or it adds one scalar, supplied with the command, to every element of a single source. Elements leave the register file one per clock, pass through a two-stage integer adder that splits the carry chain at the halfway bit, and are written back into the destination.

The host issues instructions through a valid/ready command port and watches a busy level and a one-cycle done pulse. A separate element port writes or reads one element at a time. It loads operands and fetches results while the unit is idle. Integer addition wraps modulo 2^64.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset, busy and done are 0, cmd_ready is 1, ep_rvalid is 0 and ep_rdata is 0.
- R2: While idle, ep_we writes ep_wdata into element ep_idx of register ep_reg at the next clock edge. A read request (ep_re) made while idle returns that element on ep_rdata with ep_rvalid high after the second clock edge that follows. ep_rdata holds its value at all other times.
- R3: With cmd_op = 0, element i of register cmd_vd becomes element i of cmd_vs1 plus element i of cmd_vs2, modulo 2^64, for every i from 0 to 63.
- R4: With cmd_op = 1, element i of cmd_vd becomes element i of cmd_vs1 plus cmd_scalar, modulo 2^64. cmd_vs2 has no effect in this mode.
- R5: A command is accepted on a clock edge where cmd_valid and cmd_ready are both high. busy rises on that edge. The last element is written on the 67th edge after acceptance (64 elements plus 3 register stages). busy falls on that same edge, and done is high for exactly the one cycle that follows it.
- R6: cmd_ready is the inverse of busy. A command presented while busy is refused and changes no register.
- R7: When cmd_vd equals either or both source registers, the result equals the one computed from the source values as they were before the instruction.
- R8: While busy, the element port is ignored. Writes do not change any register, and read requests produce no ep_rvalid and no change of ep_rdata.
- R9: An instruction changes no register other than cmd_vd.
- R10: The carry from bit 31 to bit 32 propagates through the split adder, so results stay correct for operands whose low halves overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle; a command is accepted |
| cmd_op | input | 1 | 0: vector plus vector, 1: vector plus scalar |
| cmd_vd | input | 5 | Destination register |
| cmd_vs1 | input | 5 | First source register |
| cmd_vs2 | input | 5 | Second source register (vector plus vector only) |
| cmd_scalar | input | 64 | Scalar operand for vector plus scalar |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse after the final element write |
| ep_we | input | 1 | Element write request |
| ep_re | input | 1 | Element read request |
| ep_reg | input | 5 | Register selected by the element port |
| ep_idx | input | 6 | Element index selected by the element port |
| ep_wdata | input | 64 | Element write data |
| ep_rdata | output | 64 | Element read data, held between reads |
| ep_rvalid | output | 1 | ep_rdata updated by a read this cycle |

## Verification
An element write takes effect on the next edge. A read result is due after the second edge, so the bench drives ep_re on a falling edge and samples ep_rdata and ep_rvalid two falling edges later. For instructions, the bench counts falling edges from the accepting edge and requires done first on count 67, with busy low in that cycle and done low on the next one. While the instruction runs it injects a refused command and element port traffic, and it checks every sample in that window for a stray ep_rvalid. Register contents are compared against a bench-side model only after done, element by element, through the element port.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  typedef enum logic {
    OP_VV = 1'b0,
    OP_VS = 1'b1
  } vop_e;
endpackage

// File: rtl/vlane_bank.sv
module vlane_bank #(
  parameter int NREG  = 32,
  parameter int NELEM = 64,
  parameter int EW    = 64,
  localparam int AW   = $clog2(NREG) + $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [EW-1:0] rdata_a,
  output logic [EW-1:0] rdata_b
);
  localparam int DEPTH = NREG * NELEM;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/vlane_adder.sv
module vlane_adder #(
  parameter int EW = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [IW-1:0] in_idx,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic          out_v,
  output logic [IW-1:0] out_idx,
  output logic [EW-1:0] sum
);
  localparam int LO = EW / 2;
  localparam int HI = EW - LO;

  logic          s1_v;
  logic [IW-1:0] s1_idx;
  logic [LO-1:0] s1_lo;
  logic          s1_c;
  logic [HI-1:0] s1_ah, s1_bh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      out_v <= 1'b0;
    end else begin
      s1_v  <= in_v;
      out_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    {s1_c, s1_lo} <= {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]};
    s1_ah   <= a[EW-1:LO];
    s1_bh   <= b[EW-1:LO];
    s1_idx  <= in_idx;
    sum     <= {s1_ah + s1_bh + {{(HI-1){1'b0}}, s1_c}, s1_lo};
    out_idx <= s1_idx;
  end

  // R5
  pipe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_v |-> ##2 out_v);
endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
  import vlane_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NELEM = 64,
  parameter int EW    = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(NELEM),
  localparam int AW   = RW + IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [RW-1:0] cmd_vd,
  input  logic [RW-1:0] cmd_vs1,
  input  logic [RW-1:0] cmd_vs2,
  input  logic [EW-1:0] cmd_scalar,
  output logic          busy,
  output logic          done,
  input  logic          ep_we,
  input  logic          ep_re,
  input  logic [RW-1:0] ep_reg,
  input  logic [IW-1:0] ep_idx,
  input  logic [EW-1:0] ep_wdata,
  output logic [EW-1:0] ep_rdata,
  output logic          ep_rvalid
);
  logic          busy_q, ready_q, done_q;
  vop_e          op_q;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [EW-1:0] scal_q;
  logic [IW:0]   cnt_q;
  logic          rv_q;
  logic [IW-1:0] ridx_q;
  logic          ep_pend_q, ep_rvalid_q;
  logic [EW-1:0] ep_rdata_q;

  logic          accept, issue, last;
  logic          bank_we;
  logic [AW-1:0] bank_waddr, raddr_a, raddr_b;
  logic [EW-1:0] bank_wdata, rdata_a, rdata_b, opnd_b;
  logic          add_v;
  logic [IW-1:0] add_idx;
  logic [EW-1:0] add_sum;

  assign accept = cmd_valid && ready_q;
  assign issue  = busy_q && !cnt_q[IW];
  assign last   = add_v && (add_idx == IW'(NELEM - 1));

  always_comb begin
    raddr_a = issue ? {vs1_q, cnt_q[IW-1:0]} : {ep_reg, ep_idx};
    raddr_b = {vs2_q, cnt_q[IW-1:0]};
    opnd_b  = (op_q == OP_VS) ? scal_q : rdata_b;
    if (busy_q) begin
      bank_we    = add_v;
      bank_waddr = {vd_q, add_idx};
      bank_wdata = add_sum;
    end else begin
      bank_we    = ep_we;
      bank_waddr = {ep_reg, ep_idx};
      bank_wdata = ep_wdata;
    end
  end

  vlane_bank #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) i_bank (
    .clk(clk), .we(bank_we), .waddr(bank_waddr), .wdata(bank_wdata),
    .raddr_a(raddr_a), .raddr_b(raddr_b), .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  vlane_adder #(.EW(EW), .IW(IW)) i_adder (
    .clk(clk), .rst(rst), .in_v(rv_q), .in_idx(ridx_q), .a(rdata_a), .b(opnd_b),
    .out_v(add_v), .out_idx(add_idx), .sum(add_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      ready_q     <= 1'b1;
      done_q      <= 1'b0;
      cnt_q       <= '0;
      rv_q        <= 1'b0;
      ep_pend_q   <= 1'b0;
      ep_rvalid_q <= 1'b0;
      ep_rdata_q  <= '0;
    end else begin
      done_q      <= 1'b0;
      rv_q        <= issue;
      ep_pend_q   <= ep_re && !busy_q;
      ep_rvalid_q <= ep_pend_q;
      if (ep_pend_q) ep_rdata_q <= rdata_a;
      if (accept) begin
        busy_q  <= 1'b1;
        ready_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        if (issue) cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q  <= 1'b0;
          ready_q <= 1'b1;
          done_q  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    ridx_q <= cnt_q[IW-1:0];
    if (accept) begin
      op_q   <= vop_e'(cmd_op);
      vd_q   <= cmd_vd;
      vs1_q  <= cmd_vs1;
      vs2_q  <= cmd_vs2;
      scal_q <= cmd_scalar;
    end
  end

  assign cmd_ready = ready_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign ep_rdata  = ep_rdata_q;
  assign ep_rvalid = ep_rvalid_q;

  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready != busy);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R8
  ep_idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    ep_rvalid |-> !$past(busy_q, 2));
  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));
endmodule

// File: tb/test_vec_lane_unit.sv
`timescale 1ns/1ps
module test_vec_lane_unit;
  localparam int NREG  = 32;
  localparam int NELEM = 64;
  localparam int EW    = 64;
  localparam int LAT   = NELEM + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_ready, cmd_op = 1'b0;
  logic [4:0]    cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
  logic [EW-1:0] cmd_scalar = '0;
  logic          busy, done;
  logic          ep_we = 1'b0, ep_re = 1'b0;
  logic [4:0]    ep_reg = '0;
  logic [5:0]    ep_idx = '0;
  logic [EW-1:0] ep_wdata = '0, ep_rdata;
  logic          ep_rvalid;

  logic [EW-1:0] mdl [NREG][NELEM];
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vec_lane_unit i_vec_lane_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2),
    .cmd_scalar(cmd_scalar), .busy(busy), .done(done),
    .ep_we(ep_we), .ep_re(ep_re), .ep_reg(ep_reg), .ep_idx(ep_idx),
    .ep_wdata(ep_wdata), .ep_rdata(ep_rdata), .ep_rvalid(ep_rvalid)
  );

  task automatic chk(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic ep_wr(input int r, input int i, input logic [EW-1:0] d);
    ep_we = 1'b1; ep_reg = 5'(r); ep_idx = 6'(i); ep_wdata = d;
    @(negedge clk);
    ep_we = 1'b0;
    mdl[r][i] = d;
  endtask

  task automatic ep_rd(input int r, input int i, output logic [EW-1:0] d);
    ep_re = 1'b1; ep_reg = 5'(r); ep_idx = 6'(i);
    @(negedge clk);
    ep_re = 1'b0;
    @(negedge clk);
    chk("R2 ep_rvalid", {63'd0, ep_rvalid}, 64'd1);
    d = ep_rdata;
  endtask

  task automatic check_reg(input int r, input string req);
    logic [EW-1:0] d;
    for (int i = 0; i < NELEM; i++) begin
      ep_rd(r, i, d);
      chk($sformatf("%s v%0d[%0d]", req, r, i), d, mdl[r][i]);
    end
  endtask

  task automatic run_cmd(input logic op, input int vd, input int s1, input int s2,
                         input logic [EW-1:0] sc, input bit disturb, input int victim);
    logic [EW-1:0] tmp [NELEM];
    int k;
    int got;
    bit rv_seen;
    for (int i = 0; i < NELEM; i++)
      tmp[i] = mdl[s1][i] + (op ? sc : mdl[s2][i]);
    cmd_valid = 1'b1; cmd_op = op; cmd_vd = 5'(vd); cmd_vs1 = 5'(s1);
    cmd_vs2 = 5'(s2); cmd_scalar = sc;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy after accept", {63'd0, busy}, 64'd1);
    chk("R6 ready low while busy", {63'd0, cmd_ready}, 64'd0);
    k = 0; got = -1; rv_seen = 0;
    while (k < LAT + 20) begin
      if (disturb && k == 5) begin
        chk("R6 ready low mid-run", {63'd0, cmd_ready}, 64'd0);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_vd = 5'(victim);
        cmd_vs1 = 5'(s1); cmd_vs2 = 5'(s2);
        ep_we = 1'b1; ep_re = 1'b1; ep_reg = 5'(victim); ep_idx = 6'd0;
        ep_wdata = ~mdl[victim][0];
      end
      if (disturb && k == 6) begin
        cmd_valid = 1'b0; ep_we = 1'b0; ep_re = 1'b0;
      end
      @(negedge clk);
      k++;
      if (ep_rvalid) rv_seen = 1;
      if (done) begin
        got = k;
        break;
      end
    end
    chk("R5 done edge count", 64'(got), 64'(LAT));
    chk("R5 busy low at done", {63'd0, busy}, 64'd0);
    chk("R8 no rvalid while busy", {63'd0, rv_seen}, 64'd0);
    @(negedge clk);
    chk("R5 done single pulse", {63'd0, done}, 64'd0);
    chk("R6 refused command not started", {63'd0, busy}, 64'd0);
    for (int i = 0; i < NELEM; i++) mdl[vd][i] = tmp[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [EW-1:0] d;
    void'($urandom(32'd9137));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 cmd_ready", {63'd0, cmd_ready}, 64'd1);
    chk("R1 ep_rvalid", {63'd0, ep_rvalid}, 64'd0);
    chk("R1 ep_rdata", ep_rdata, 64'd0);

    // R2 fill every register through the element port
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NELEM; i++) begin
        if (r == 1) d = '1;
        else if (r == 2) d = (i % 2 == 0) ? 64'h0000_0000_FFFF_FFFF : rnd64();
        else if (r == 3) d = (i % 2 == 0) ? 64'h0000_0000_0000_0001 : rnd64();
        else d = rnd64();
        ep_wr(r, i, d);
      end
    check_reg(0, "R2");
    ep_rd(31, 63, d);
    chk("R2 last element", d, mdl[31][63]);
    @(negedge clk);
    chk("R2 rdata held", ep_rdata, mdl[31][63]);

    // R10 carry across the half boundary
    run_cmd(1'b0, 4, 2, 3, 64'd0, 0, 0);
    check_reg(4, "R10");
    // R4 scalar broadcast with wrap, vs2 ignored
    run_cmd(1'b1, 5, 1, 0, 64'd1, 0, 0);
    check_reg(5, "R4");
    run_cmd(1'b1, 16, 0, 1, rnd64(), 0, 0);
    check_reg(16, "R4");
    // R3 with disturbance, R8 victim unchanged
    run_cmd(1'b0, 6, 7, 8, 64'd0, 1, 9);
    check_reg(6, "R3");
    check_reg(9, "R8");
    // R7 in-place variants, back to back
    run_cmd(1'b0, 10, 10, 11, 64'd0, 0, 0);
    run_cmd(1'b1, 12, 12, 0, rnd64(), 0, 0);
    run_cmd(1'b0, 13, 14, 13, 64'd0, 0, 0);
    run_cmd(1'b0, 15, 15, 15, 64'd0, 0, 0);
    check_reg(10, "R7");
    check_reg(12, "R7");
    check_reg(13, "R7");
    check_reg(15, "R7");
    // R3 R4 random commands
    for (int n = 0; n < 6; n++)
      run_cmd(1'($urandom()), int'($urandom() % 32), int'($urandom() % 32),
              int'($urandom() % 32), rnd64(), n == 2, 20);
    // R9 whole file against the model
    for (int r = 0; r < NREG; r++) check_reg(r, "R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule